// File: doc/BRIEF.md
# I2C SCL Period Generator

This block is the clock half of an I2C master. It produces the SCL waveform from two programmable counts: one sets how long the block holds SCL low, and the other sets how long SCL stays high. Each count is nine bits wide. The lower eight bits come from their own byte registers. The ninth bit of each count comes from the interrupt-control register, where bit 7 extends the low count and bit 6 extends the high count. A prescaler select makes one count tick equal to one or two system clocks.

The low phase starts counting in the cycle in which the block asserts its open-drain pull-down. Any fall time on the line is therefore used up inside the low phase. The high phase works differently. After releasing SCL, the block waits until the synchronised SCL input reads high, and only then starts counting. This absorbs rise time and slave clock stretching. The high count also times the START hold: when the generator is enabled, SCL stays released for one high interval before the first low phase. A byte engine next to the block watches single-cycle pulses that mark the end of the START hold, of each low phase and of each high phase.

Top module: `scl_period_gen`

## Requirements
- R1: A low phase keeps `scl_pull` high for exactly Lt·k cycles. Lt = {`low_cnt_hi`,`low_cnt`}, and k = 1 when `half_rate` is 0 or 2 when `half_rate` is 1.
- R2: Counting of a high phase starts only after the synchronised SCL input is seen high. With the line rising D cycles after release, `scl_pull` therefore stays low for D + 3 + Ht·k cycles. Ht = {`high_cnt_hi`,`high_cnt`}.
- R3: While SCL is released but the line is held low, the generator waits indefinitely. It asserts no `high_done` and does not pull SCL.
- R4: Each count is nine bits. `low_cnt_hi` (bit 7 of the interrupt-control register) is bit 8 of the low count, and `high_cnt_hi` (bit 6) is bit 8 of the high count. Values up to 0x1FF are usable.
- R5: When `half_rate` is 1, one tick lasts two clocks, so every counted interval is twice as long.
- R6: A count below 2 is treated as 2. This keeps each phase longer than the input synchroniser latency.
- R7: When `enable` rises from idle, SCL stays released for Ht·k cycles. `start_done` pulses in the last of those cycles, and the next cycle begins a low phase.
- R8: `low_done` pulses in the last cycle of each low phase and `high_done` in the last cycle of each high phase. At most one done pulse is active in any cycle, and `scl_pull` rises only right after `start_done` or `high_done`.
- R9: When `enable` is low, SCL is released from the next cycle on and no done pulse occurs while idle.
- R10: Out of reset, `scl_pull` and all done pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low returns it to idle |
| half_rate | input | 1 | 1: two clocks per count tick; 0: one |
| low_cnt | input | 8 | Low count bits 7:0 |
| high_cnt | input | 8 | High count bits 7:0 |
| low_cnt_hi | input | 1 | Low count bit 8 (interrupt-control bit 7) |
| high_cnt_hi | input | 1 | High count bit 8 (interrupt-control bit 6) |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull | output | 1 | 1 = drive SCL low (open-drain enable) |
| start_done | output | 1 | Last cycle of the START hold |
| low_done | output | 1 | Last cycle of a low phase |
| high_done | output | 1 | Last cycle of a high phase |

## Verification
A low phase lasts Lt·k cycles, beginning with the edge that raises `scl_pull`. A released phase lasts D + 3 + Ht·k cycles: two synchroniser stages, one cycle to leave the wait state, and then the count. The START hold lasts Ht·k cycles and begins one edge after `enable` is raised. The bench drives inputs and the line model on the falling clock edge and samples on falling edges. It measures the length of each run of `scl_pull` and compares it with these formulas. The done flag seen on the last sample of a run must be set, and `scl_pull` must be low one sample after `enable` drops.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOW,
    ST_RISE,
    ST_HIGH
  } phase_e;

  // Raise a programmed count to the minimum tick count the phase may use.
  function automatic logic [15:0] floor_count(input logic [15:0] raw,
                                              input logic [15:0] floor_val);
    return (raw < floor_val) ? floor_val : raw;
  endfunction
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic half_rate,
  output logic tick
);
  logic pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= 1'b0;
    else if (!run || restart)  pre <= 1'b0;
    else if (half_rate)        pre <= ~pre;
    else                       pre <= 1'b0;
  end

  assign tick = run & (~half_rate | pre);
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = tick & (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || last)  cnt <= '0;
    else if (tick)          cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int BYTE_W      = 8,
  parameter bit WIDE_COUNT  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              half_rate,
  input  logic [BYTE_W-1:0] low_cnt,
  input  logic [BYTE_W-1:0] high_cnt,
  input  logic              low_cnt_hi,
  input  logic              high_cnt_hi,
  input  logic              scl_in,
  output logic              scl_pull,
  output logic              start_done,
  output logic              low_done,
  output logic              high_done
);
  import scl_gen_pkg::*;

  localparam int CNT_W     = BYTE_W + 1;
  localparam int MIN_TICKS = SYNC_STAGES;

  phase_e           state, state_nx;
  logic [CNT_W-1:0] low_raw, high_raw, low_eff, high_eff, cur_limit;
  logic             scl_sync, counting, tick, last;
  logic             rise_wait;

  generate
    if (WIDE_COUNT) begin : g_wide
      assign low_raw  = {low_cnt_hi, low_cnt};
      assign high_raw = {high_cnt_hi, high_cnt};
    end else begin : g_narrow
      assign low_raw  = {1'b0, low_cnt};
      assign high_raw = {1'b0, high_cnt};
    end
  endgenerate

  assign low_eff  = CNT_W'(floor_count(16'(low_raw), 16'(MIN_TICKS)));
  assign high_eff = CNT_W'(floor_count(16'(high_raw), 16'(MIN_TICKS)));

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n(rst_n), .din(scl_in), .dout(scl_sync)
  );

  assign counting  = (state == ST_HOLD) || (state == ST_LOW) || (state == ST_HIGH);
  assign cur_limit = (state == ST_LOW) ? low_eff : high_eff;
  assign rise_wait = (state == ST_RISE);

  scl_tick_div u_div (
    .clk(clk), .rst_n(rst_n), .run(counting), .restart(last),
    .half_rate(half_rate), .tick(tick)
  );

  scl_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(counting), .tick(tick),
    .limit(cur_limit), .last(last)
  );

  always_comb begin
    state_nx = state;
    if (!enable) state_nx = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: state_nx = ST_HOLD;
        ST_HOLD: if (last)     state_nx = ST_LOW;
        ST_LOW:  if (last)     state_nx = ST_RISE;
        ST_RISE: if (scl_sync) state_nx = ST_HIGH;
        ST_HIGH: if (last)     state_nx = ST_LOW;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign scl_pull   = (state == ST_LOW);
  assign start_done = (state == ST_HOLD) & last;
  assign low_done   = (state == ST_LOW)  & last;
  assign high_done  = (state == ST_HIGH) & last;
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_pull,
  input logic start_done,
  input logic low_done,
  input logic high_done,
  input logic rise_wait,
  input logic scl_sync
);
  assert_low_end_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |=> !scl_pull);

  assert_stretch_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_wait && !scl_sync) |=> (!scl_pull && !high_done));

  assert_hold_then_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_done && enable) |=> scl_pull);

  assert_high_then_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (high_done && enable) |=> scl_pull);

  assert_one_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_done, low_done, high_done}));

  assert_pull_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> ($past(start_done) || $past(high_done)));

  assert_disable_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull && !start_done && !low_done && !high_done));
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_pull(scl_pull),
  .start_done(start_done), .low_done(low_done), .high_done(high_done),
  .rise_wait(rise_wait), .scl_sync(scl_sync)
);

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, half_rate = 1'b0;
  logic [7:0] low_cnt = 8'd0, high_cnt = 8'd0;
  logic low_cnt_hi = 1'b0, high_cnt_hi = 1'b0;
  logic scl_pull, start_done, low_done, high_done;
  logic hold_low = 1'b0;
  logic scl_line;
  int stretch_d = 0;
  int relc = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // Open-drain line: low while pulled or while a slave stretches.
  assign scl_line = ~scl_pull & ~hold_low;

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_rate(half_rate),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .low_cnt_hi(low_cnt_hi),
    .high_cnt_hi(high_cnt_hi), .scl_in(scl_line), .scl_pull(scl_pull),
    .start_done(start_done), .low_done(low_done), .high_done(high_done)
  );

  function automatic int ticks_of(input logic hi, input logic [7:0] lo);
    int v;
    v = int'(hi) * 256 + int'(lo);
    if (v < 2) v = 2;
    return v;
  endfunction

  function automatic int exp_low();
    return ticks_of(low_cnt_hi, low_cnt) * (half_rate ? 2 : 1);
  endfunction

  function automatic int exp_high_count();
    return ticks_of(high_cnt_hi, high_cnt) * (half_rate ? 2 : 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Slave model: holds the line low for stretch_d cycles after each release.
  initial begin
    forever begin
      @(negedge clk);
      if (scl_pull) begin
        relc = 0;
        hold_low = 1'b1;
      end else begin
        hold_low = (relc < stretch_d);
        relc++;
      end
    end
  end

  task automatic burst(input logic [7:0] lo, input logic [7:0] hi,
                       input logic lhi, input logic hhi, input logic hr,
                       input int d, input int phases, input string tag);
    int n;
    logic flag;
    @(negedge clk);
    low_cnt = lo; high_cnt = hi; low_cnt_hi = lhi; high_cnt_hi = hhi;
    half_rate = hr; stretch_d = d;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    n = 0; flag = 1'b0;
    forever begin
      @(negedge clk);
      if (scl_pull) break;
      n++; flag = start_done;
    end
    check({"R7 hold ", tag}, n, exp_high_count());
    check({"R7 start_done ", tag}, int'(flag), 1);
    for (int p = 0; p < phases; p++) begin
      n = 1; flag = low_done;
      forever begin
        @(negedge clk);
        if (!scl_pull) break;
        n++; flag = low_done;
      end
      check({"R1 low length ", tag}, n, exp_low());
      check({"R8 low_done ", tag}, int'(flag), 1);
      n = 1; flag = high_done;
      forever begin
        @(negedge clk);
        if (scl_pull) break;
        n++; flag = high_done;
      end
      check({"R2 high length ", tag}, n, d + 3 + exp_high_count());
      check({"R8 high_done ", tag}, int'(flag), 1);
    end
    enable = 1'b0;
    n = 0;
    repeat (12) begin
      @(negedge clk);
      if (scl_pull || start_done || low_done || high_done) n++;
    end
    check({"R9 idle activity ", tag}, n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 pull in reset", int'(scl_pull), 0);
    check("R10 done in reset", int'(start_done | low_done | high_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 pull after reset", int'(scl_pull), 0);
    check("R9 idle after reset", int'(start_done | low_done | high_done), 0);

    burst(8'd5, 8'd4, 1'b0, 1'b0, 1'b0, 0, 3, "basic");
    burst(8'd5, 8'd4, 1'b0, 1'b0, 1'b1, 0, 2, "R5 half rate");
    burst(8'd0, 8'd1, 1'b0, 1'b0, 1'b0, 0, 2, "R6 floor");
    burst(8'd1, 8'd0, 1'b0, 1'b0, 1'b1, 2, 2, "R6 floor half");
    burst(8'd3, 8'd3, 1'b0, 1'b0, 1'b0, 60, 2, "R3 stretch");
    burst(8'd2, 8'd2, 1'b0, 1'b0, 1'b0, 1, 2, "R2 rise delay");
    burst(8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 0, 1, "R4 low ninth");
    burst(8'h03, 8'h02, 1'b0, 1'b1, 1'b1, 0, 1, "R4 high ninth");
    burst(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 0, 1, "R4 max");

    for (int i = 0; i < 25; i++) begin
      burst(8'($urandom_range(0, 40)), 8'($urandom_range(0, 40)),
            1'b0, 1'b0, 1'($urandom_range(0, 1)),
            $urandom_range(0, 6), 2, "random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule